// File: doc/BRIEF.md
# Two-Bank Parallel Flash Bus Front-End

This block is the pin-facing front end of a two-bank parallel NOR-style memory, written as a synthesizable model. It decodes three active-low strobes (chip select, output gate and write strobe) into read, write, output-disable and standby conditions. A width pin picks between a 16-bit word bus and an 8-bit byte bus. In byte mode the top data pin becomes an extra address input that picks one half of the addressed word. Real tristate buffers are replaced by a data-out vector and a per-bit drive-enable vector, so a wrapper at the chip edge can build the pads.

Storage is a small register array split into two banks. The top word-address bit selects the bank. Each bank has a busy input that stands for a program or erase running in that bank. A read from a busy bank returns a fixed status value. A read from the other bank returns its array data in the same cycle. After reset every bank is in read-array mode and holds a known boot pattern, so the first read needs no command. Simple strobed writes load words or bytes into a bank that is not busy.

Top module: `flash_bus_front`

## Requirements
- R1: `bus_oe` is driven non-zero only while `cs_n`=0, `rd_n`=0 and `wr_n`=1. In particular, `wr_n`=0 forces `bus_oe`=0.
- R2: After reset, with no command issued, a read of word address a returns {~a[7:0], a[7:0]} in both banks.
- R3: Word mode (`wide_n`=1) during a read: `bus_oe`=16'hFFFF and `bus_out` is the addressed 16-bit word, in the same cycle as the address.
- R4: Byte mode (`wide_n`=0) during a read: `bus_oe`=16'h00FF, so bits 15:8 are undriven. `bus_in[15]` is the lowest byte-address bit: 0 puts word bits 7:0 on `bus_out[7:0]`, and 1 puts word bits 15:8 there.
- R5: With `cs_n`=1 (standby), `bus_oe`=0 whatever the other inputs are.
- R6: With `cs_n`=0 and `rd_n`=1 (output disable), `bus_oe`=0.
- R7: A read of a bank whose `bank_busy` bit is set returns the status word 16'h8080 (byte mode: 8'h80). A read of the other bank in the same cycle returns its array data. Bank 0 holds word addresses 0–31 and bank 1 holds 32–63.
- R8: At a rising clock edge with `cs_n`=0, `wr_n`=0 and `rd_n`=1, a non-busy bank stores data. In word mode it stores `bus_in` at `word_addr`. In byte mode it stores `bus_in[7:0]` into the byte that `bus_in[15]` selects, and leaves the other byte unchanged. The new data is seen on the first read after that edge.
- R9: A write to a bank whose `bank_busy` bit is set leaves the stored word unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the array writes |
| rst_n | input | 1 | Active-low reset; loads the boot pattern |
| cs_n | input | 1 | Active-low chip select |
| rd_n | input | 1 | Active-low output gate |
| wr_n | input | 1 | Active-low write strobe |
| wide_n | input | 1 | 1 = 16-bit word bus, 0 = 8-bit byte bus |
| word_addr | input | 6 | Word address; the top bit selects the bank |
| bank_busy | input | 2 | Per-bank busy flag (program/erase in progress) |
| bus_in | input | 16 | Data pins as inputs; bit 15 is the low byte-address bit in byte mode |
| bus_out | output | 16 | Data pins output value |
| bus_oe | output | 16 | Per-pin drive enable |

## Verification
The whole read path is combinational, so `bus_out` and `bus_oe` follow the strobes, width pin, address and busy inputs in the same cycle with no register on the way. The bench therefore changes inputs on the falling edge and samples one nanosecond later, well before the next rising edge. A write is captured at the first rising edge that sees the write strobes. The bench holds them for exactly that one edge, removes them on the next falling edge, and only then reads back, so the stored value is due on that first read.

// File: rtl/flash_fe_pkg.sv
package flash_fe_pkg;
  localparam int BUS_W  = 16;
  localparam int LANE_W = BUS_W / 2;
  localparam logic [BUS_W-1:0] BUSY_STATUS = 16'h8080;

  // Boot content of word address a: high byte is the inverse of the low byte.
  function automatic logic [BUS_W-1:0] boot_word(input logic [LANE_W-1:0] a);
    return {~a, a};
  endfunction

  // Pick one byte lane of a word.
  function automatic logic [LANE_W-1:0] lane_of(input logic [BUS_W-1:0] w, input logic hi);
    return hi ? w[BUS_W-1:LANE_W] : w[LANE_W-1:0];
  endfunction

  // Merge a byte-lane-masked write into a stored word.
  function automatic logic [BUS_W-1:0] merge_lanes(input logic [BUS_W-1:0] old_w,
                                                   input logic [BUS_W-1:0] new_w,
                                                   input logic [1:0] mask);
    return {mask[1] ? new_w[BUS_W-1:LANE_W] : old_w[BUS_W-1:LANE_W],
            mask[0] ? new_w[LANE_W-1:0]     : old_w[LANE_W-1:0]};
  endfunction
endpackage

// File: rtl/flash_strobe_decode.sv
module flash_strobe_decode (
  input  logic cs_n,
  input  logic rd_n,
  input  logic wr_n,
  output logic read_ev,
  output logic write_ev,
  output logic standby
);
  always_comb begin
    standby  = cs_n;
    read_ev  = !cs_n && !rd_n && wr_n;
    write_ev = !cs_n && rd_n && !wr_n;
  end
endmodule

// File: rtl/flash_bank_store.sv
module flash_bank_store
  import flash_fe_pkg::*;
#(
  parameter int IDX_W = 5,
  parameter int BASE  = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_mask,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [BUS_W-1:0] wr_data,
  input  logic             busy,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [BUS_W-1:0] rd_data
);
  localparam int DEPTH = 1 << IDX_W;

  logic [BUS_W-1:0] mem [DEPTH];
  logic             write_go;

  assign write_go = wr_en && !busy;
  assign rd_data  = mem[rd_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= boot_word(LANE_W'(BASE + i));
    end else if (write_go) begin
      mem[wr_idx] <= merge_lanes(mem[wr_idx], wr_data, wr_mask);
    end
  end

  AST_BUSY_WRITE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && busy && rd_idx == wr_idx) |=> (rd_idx != $past(rd_idx)) || $stable(rd_data)); // R9

  AST_FULL_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !busy && wr_mask == 2'b11) |=> (rd_idx != $past(wr_idx)) || (rd_data == $past(wr_data))); // R8
endmodule

// File: rtl/flash_lane_steer.sv
module flash_lane_steer
  import flash_fe_pkg::*;
(
  input  logic             read_ev,
  input  logic             wide_n,
  input  logic             lane_hi,
  input  logic [BUS_W-1:0] word_in,
  output logic [BUS_W-1:0] bus_out,
  output logic [BUS_W-1:0] bus_oe
);
  always_comb begin
    bus_out = '0;
    bus_oe  = '0;
    if (read_ev) begin
      if (wide_n) begin
        bus_out = word_in;
        bus_oe  = '1;
      end else begin
        bus_out[LANE_W-1:0] = lane_of(word_in, lane_hi);
        bus_oe[LANE_W-1:0]  = '1;
      end
    end
  end
endmodule

// File: rtl/flash_bus_front.sv
module flash_bus_front
  import flash_fe_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int NBANK  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic              wide_n,
  input  logic [ADDR_W-1:0] word_addr,
  input  logic [NBANK-1:0]  bank_busy,
  input  logic [BUS_W-1:0]  bus_in,
  output logic [BUS_W-1:0]  bus_out,
  output logic [BUS_W-1:0]  bus_oe
);
  localparam int BSEL_W = $clog2(NBANK);
  localparam int IDX_W  = ADDR_W - BSEL_W;
  localparam int DEPTH  = 1 << IDX_W;

  logic              read_ev, write_ev, standby;
  logic [BSEL_W-1:0] bank_sel;
  logic [IDX_W-1:0]  word_idx;
  logic              lane_hi;
  logic [BUS_W-1:0]  wr_word;
  logic [1:0]        wr_mask;
  logic [BUS_W-1:0]  bank_rd [NBANK];
  logic [BUS_W-1:0]  sel_word;
  logic              sel_busy;

  assign bank_sel = word_addr[ADDR_W-1 -: BSEL_W];
  assign word_idx = word_addr[IDX_W-1:0];
  assign lane_hi  = bus_in[BUS_W-1];
  assign wr_word  = wide_n ? bus_in : {bus_in[LANE_W-1:0], bus_in[LANE_W-1:0]};
  assign wr_mask  = wide_n ? 2'b11 : (lane_hi ? 2'b10 : 2'b01);
  assign sel_busy = bank_busy[bank_sel];
  assign sel_word = sel_busy ? BUSY_STATUS : bank_rd[bank_sel];

  flash_strobe_decode u_dec (
    .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
    .read_ev(read_ev), .write_ev(write_ev), .standby(standby)
  );

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic bank_wr;
    assign bank_wr = write_ev && (bank_sel == BSEL_W'(b));
    flash_bank_store #(.IDX_W(IDX_W), .BASE(b * DEPTH)) u_store (
      .clk(clk), .rst_n(rst_n),
      .wr_en(bank_wr), .wr_mask(wr_mask), .wr_idx(word_idx), .wr_data(wr_word),
      .busy(bank_busy[b]), .rd_idx(word_idx), .rd_data(bank_rd[b])
    );
  end

  flash_lane_steer u_steer (
    .read_ev(read_ev), .wide_n(wide_n), .lane_hi(lane_hi),
    .word_in(sel_word), .bus_out(bus_out), .bus_oe(bus_oe)
  );

  AST_WRITE_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_n |-> bus_oe == '0); // R1
  AST_STANDBY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    standby |-> bus_oe == '0); // R5
  AST_OUTPUT_DISABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && rd_n) |-> bus_oe == '0); // R6
  AST_BYTE_UPPER_FLOAT: assert property (@(posedge clk) disable iff (!rst_n)
    !wide_n |-> bus_oe[BUS_W-1:LANE_W] == '0); // R4
  AST_WORD_FULL_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && !rd_n && wr_n && wide_n) |-> bus_oe == '1); // R3
  AST_BUSY_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && !rd_n && wr_n && wide_n && sel_busy) |-> bus_out == BUSY_STATUS); // R7
endmodule

// File: tb/tb_flash_bus_front.sv
module tb_flash_bus_front;
  logic        clk = 0, rst_n = 0;
  logic        cs_n = 1, rd_n = 1, wr_n = 1, wide_n = 1;
  logic [5:0]  word_addr = '0;
  logic [1:0]  bank_busy = '0;
  logic [15:0] bus_in = '0;
  logic [15:0] bus_out, bus_oe;
  int          n_run = 0, n_fail = 0;
  bit          done = 0;
  logic [15:0] model [64];

  always #2 clk = ~clk;

  flash_bus_front dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n), .wide_n(wide_n),
    .word_addr(word_addr), .bank_busy(bank_busy), .bus_in(bus_in),
    .bus_out(bus_out), .bus_oe(bus_oe)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Set the bus on a falling edge, then sample 1 ns later.
  task automatic drive(input logic c, input logic r, input logic w, input logic wd,
                       input logic [5:0] a, input logic [15:0] d);
    @(negedge clk);
    cs_n = c; rd_n = r; wr_n = w; wide_n = wd; word_addr = a; bus_in = d;
    #1;
  endtask

  task automatic do_write(input logic wd, input logic [5:0] a, input logic [15:0] d);
    drive(0, 1, 0, wd, a, d);
    check("R1 oe during write", bus_oe, 16'h0000);
    @(posedge clk);
    if (!bank_busy[a[5]]) begin
      if (wd) model[a] = d;
      else if (d[15]) model[a][15:8] = d[7:0];
      else model[a][7:0] = d[7:0];
    end
    drive(1, 1, 1, wd, a, 16'h0);
  endtask

  task automatic t_reset;
    for (int a = 0; a < 64; a++) model[a] = {~a[7:0], a[7:0]};
    check("R5 oe in reset idle", bus_oe, 16'h0000);
    drive(0, 0, 1, 1, 6'd5, 16'h0);
    check("R2 boot word bank0", bus_out, 16'hFA05);
    drive(0, 0, 1, 1, 6'd40, 16'h0);
    check("R2 boot word bank1", bus_out, model[40]);
  endtask

  task automatic t_word_read;
    for (int a = 0; a < 64; a += 9) begin
      drive(0, 0, 1, 1, 6'(a), 16'h1234);
      check("R3 word data", bus_out, model[a]);
      check("R3 word oe", bus_oe, 16'hFFFF);
    end
  endtask

  task automatic t_byte_read;
    drive(0, 0, 1, 0, 6'd3, 16'h0000);
    check("R4 byte low lane", bus_out, {8'h00, model[3][7:0]});
    check("R4 byte oe", bus_oe, 16'h00FF);
    drive(0, 0, 1, 0, 6'd3, 16'h8000);
    check("R4 byte high lane", bus_out, {8'h00, model[3][15:8]});
    check("R4 byte oe hi sel", bus_oe, 16'h00FF);
  endtask

  task automatic t_quiet;
    drive(1, 0, 1, 1, 6'd7, 16'h0);
    check("R5 standby oe", bus_oe, 16'h0000);
    drive(1, 0, 0, 0, 6'd7, 16'h0);
    check("R5 standby oe other pins", bus_oe, 16'h0000);
    drive(0, 1, 1, 1, 6'd7, 16'h0);
    check("R6 output disable oe", bus_oe, 16'h0000);
    drive(0, 0, 0, 1, 6'd7, 16'h0);
    check("R1 all strobes low oe", bus_oe, 16'h0000);
  endtask

  task automatic t_busy;
    bank_busy = 2'b10;
    drive(0, 0, 1, 1, 6'd33, 16'h0);
    check("R7 busy bank status", bus_out, 16'h8080);
    drive(0, 0, 1, 1, 6'd2, 16'h0);
    check("R7 idle bank data", bus_out, model[2]);
    drive(0, 0, 1, 0, 6'd33, 16'h8000);
    check("R7 busy bank byte status", bus_out, 16'h0080);
    bank_busy = 2'b01;
    drive(0, 0, 1, 1, 6'd33, 16'h0);
    check("R7 bank1 after busy swap", bus_out, model[33]);
    bank_busy = 2'b00;
  endtask

  task automatic t_write;
    do_write(1, 6'd10, 16'hBEEF);
    drive(0, 0, 1, 1, 6'd10, 16'h0);
    check("R8 word write", bus_out, 16'hBEEF);
    do_write(0, 6'd10, 16'h8012);
    drive(0, 0, 1, 1, 6'd10, 16'h0);
    check("R8 byte write high lane", bus_out, 16'h12EF);
    do_write(0, 6'd50, 16'h0077);
    drive(0, 0, 1, 1, 6'd50, 16'h0);
    check("R8 byte write low lane", bus_out, model[50]);
  endtask

  task automatic t_write_busy;
    bank_busy = 2'b01;
    do_write(1, 6'd12, 16'h5555);
    bank_busy = 2'b00;
    drive(0, 0, 1, 1, 6'd12, 16'h0);
    check("R9 busy write ignored", bus_out, {~8'd12, 8'd12});
    do_write(1, 6'd44, 16'hA0A0);
    drive(0, 0, 1, 1, 6'd44, 16'h0);
    check("R8 bank1 write while bank0 idle", bus_out, 16'hA0A0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    t_reset();
    t_word_read();
    t_byte_read();
    t_quiet();
    t_busy();
    t_write();
    t_write_busy();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule